// File: doc/BRIEF.md
# I2C START/STOP Condition Detector

This block watches the SCL and SDA lines of a two-wire bus and reports START and STOP conditions only when the line timing around them meets programmable limits. Each line first passes through a two-flop synchronizer and then a persistence filter. A falling SDA edge while SCL is high is a START candidate. A rising SDA edge while SCL is high is a STOP candidate. A candidate is accepted only if three checks pass. SCL must have been high long enough before the edge (release time). SDA must have held its previous level long enough before the edge (setup time). SCL must stay high and SDA must stay unchanged long enough after the edge (hold time).

The block counts all timing in half system-clock cycles, so limits such as 12.5 cycles are exact. Each clock adds two half-units. An accepted condition produces a one-cycle pulse. The bus-busy flag then changes after a separate settling delay that depends on the mode: it goes to 1 for a START and to 0 for a STOP. A STOP that is seen while the block is a bus slave also raises a one-cycle interrupt request.

Timing comes from two controls. A 5-bit value S sets the limits in standard mode. In high-speed mode the limits are fixed. Zero and odd values of S are not meant to be programmed. If they are, the block uses the next larger even value E, so it can never deadlock.

Top module: `i2c_cond_detector`

## Requirements
- R1: After reset, start_pulse, stop_pulse, irq and bus_busy are 0.
- R2: A falling SDA edge with SCL high that passes all three checks produces a one-cycle start_pulse. The pulse is high in the clock cycle that begins at rising edge 5+K, where edge 0 is the edge after which the SDA input changed and K = ceil(hold/2). Both lines are delayed equally by the input path.
- R3: A rising SDA edge with SCL high that passes all three checks produces a one-cycle stop_pulse, timed as in R2.
- R4: In standard mode, the release check needs SCL high for at least 2E+2 half-cycles. Counted in input changes, SCL must rise at least E+1 cycles before the SDA edge, or no condition is reported.
- R5: In standard mode, the setup check needs SDA at its prior level for at least E+1 half-cycles. This means at least E/2+1 whole cycles between SDA input changes, or no condition is reported.
- R6: In standard mode, the hold check needs SCL high and SDA unchanged for E+1 half-cycles after the edge. If the SCL input falls K cycles or fewer after the SDA change, no condition is reported.
- R7: bus_busy takes its new value (1 after START, 0 after STOP) from the cycle that begins at edge 5+M, with M = ceil(busy_delay/2). The busy delay is E+3 half-cycles in standard mode and 7 half-cycles in high-speed mode.
- R8: With hs_mode=1, the limits are fixed and do not depend on S. In half-cycles they are: release 8, setup 4, hold 4, busy delay 7.
- R9: S=0 is treated as E=2. An odd S is treated as E=S+1.
- R10: irq pulses together with stop_pulse when master_mode=0. It stays 0 when master_mode=1 and for every START.
- R11: A START accepted while bus_busy=1 is still reported, and bus_busy stays 1.
- R12: A line pulse shorter than FILT_LEN cycles (default 2) after synchronization is filtered out. It neither resets the timing counters nor creates an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| hs_mode | input | 1 | 1 selects the fixed high-speed limits |
| scc_cfg | input | 5 | Standard-mode timing value S |
| master_mode | input | 1 | 1 when the local node is bus master |
| start_pulse | output | 1 | One-cycle pulse for an accepted START |
| stop_pulse | output | 1 | One-cycle pulse for an accepted STOP |
| bus_busy | output | 1 | Set by START and cleared by STOP after the busy delay |
| irq | output | 1 | One-cycle request for a STOP seen in slave mode |

## Verification
The assertions check, on every cycle, the rules that hold at any moment:
- START and STOP pulses never coincide and each lasts only one cycle.
- The interrupt follows exactly the STOP-in-slave-mode rule.
- A report is only made while SCL was still high in the cycle before.
- A filtered line only changes to a level the synchronizer already showed.

Other behaviour can only be shown by the bench's scenarios: the exact cycle of each pulse and of each busy change, the accept or reject outcome just at and just below each release, setup and hold limit, the high-speed limits, the normalization of illegal S values, repeated START and glitch rejection.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
  localparam int SCC_W = 5;
  localparam int HW    = 8;
  typedef logic [HW-1:0] half_t;
  localparam half_t HALF_MAX = '1;

  typedef enum logic [1:0] {Q_IDLE, Q_HOLD, Q_SETTLE} qual_state_e;

  // Even, non-zero version of the timing value
  function automatic logic [SCC_W:0] eff_scc(input logic [SCC_W-1:0] s);
    logic [SCC_W:0] v;
    v = {1'b0, s};
    if (v == '0)   v = (SCC_W+1)'(2);
    else if (v[0]) v = v + (SCC_W+1)'(1);
    return v;
  endfunction

  function automatic half_t release_half(input logic hs, input logic [SCC_W-1:0] s);
    half_t e;
    e = half_t'(eff_scc(s));
    return hs ? half_t'(8) : (e << 1) + half_t'(2);
  endfunction

  function automatic half_t setup_half(input logic hs, input logic [SCC_W-1:0] s);
    return hs ? half_t'(4) : half_t'(eff_scc(s)) + half_t'(1);
  endfunction

  function automatic half_t hold_half(input logic hs, input logic [SCC_W-1:0] s);
    return hs ? half_t'(4) : half_t'(eff_scc(s)) + half_t'(1);
  endfunction

  function automatic half_t busy_half(input logic hs, input logic [SCC_W-1:0] s);
    return hs ? half_t'(7) : half_t'(eff_scc(s)) + half_t'(3);
  endfunction

  // One system clock = two half-units, saturating
  function automatic half_t add_clock(input half_t v);
    return (v >= HALF_MAX - half_t'(1)) ? HALF_MAX : v + half_t'(2);
  endfunction
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic sync_o,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN) + 1;

  logic          meta_q, sync_q, filt_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      filt_q <= 1'b1;
      run_q  <= '0;
    end else begin
      meta_q <= line_in;
      sync_q <= meta_q;
      if (sync_q != filt_q) begin
        if (run_q == CW'(FILT_LEN - 1)) begin
          filt_q <= sync_q;
          run_q  <= '0;
        end else begin
          run_q <= run_q + CW'(1);
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign sync_o = sync_q;
  assign filt_o = filt_q;
endmodule

// File: rtl/i2c_line_timers.sv
module i2c_line_timers
  import i2c_cond_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  scl_f,
  input  logic  sda_f,
  output logic  sda_edge,
  output half_t scl_high_half,
  output half_t sda_stable_half
);
  logic  sda_prev_q;
  half_t scl_high_q, sda_stable_q;

  assign sda_edge = sda_f ^ sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_prev_q   <= 1'b1;
      scl_high_q   <= '0;
      sda_stable_q <= HALF_MAX;
    end else begin
      sda_prev_q   <= sda_f;
      scl_high_q   <= scl_f ? add_clock(scl_high_q) : '0;
      sda_stable_q <= sda_edge ? half_t'(2) : add_clock(sda_stable_q);
    end
  end

  assign scl_high_half   = scl_high_q;
  assign sda_stable_half = sda_stable_q;
endmodule

// File: rtl/i2c_cond_qual.sv
module i2c_cond_qual
  import i2c_cond_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  scl_f,
  input  logic  sda_f,
  input  logic  sda_edge,
  input  half_t scl_high_half,
  input  half_t sda_stable_half,
  input  half_t rel_thr,
  input  half_t setup_thr,
  input  half_t hold_thr,
  input  half_t busy_thr,
  input  logic  master_mode,
  output logic  start_pulse,
  output logic  stop_pulse,
  output logic  irq,
  output logic  bus_busy
);
  qual_state_e state_q;
  half_t       elap_q;
  logic        is_stop_q;

  logic cand_w, hold_ok_w, fire_w, settle_w;

  assign cand_w    = (state_q == Q_IDLE) && sda_edge && scl_f &&
                     (scl_high_half >= rel_thr) && (sda_stable_half >= setup_thr);
  assign hold_ok_w = scl_f && !sda_edge;
  assign fire_w    = (state_q == Q_HOLD) && hold_ok_w && (elap_q >= hold_thr);
  assign settle_w  = (state_q == Q_SETTLE) && (elap_q >= busy_thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= Q_IDLE;
      elap_q      <= '0;
      is_stop_q   <= 1'b0;
      start_pulse <= 1'b0;
      stop_pulse  <= 1'b0;
      irq         <= 1'b0;
      bus_busy    <= 1'b0;
    end else begin
      start_pulse <= fire_w && !is_stop_q;
      stop_pulse  <= fire_w && is_stop_q;
      irq         <= fire_w && is_stop_q && !master_mode;
      unique case (state_q)
        Q_IDLE: if (cand_w) begin
          state_q   <= Q_HOLD;
          elap_q    <= half_t'(2);
          is_stop_q <= sda_f;
        end
        Q_HOLD: begin
          if (!hold_ok_w)  state_q <= Q_IDLE;
          else begin
            if (fire_w) state_q <= Q_SETTLE;
            elap_q <= add_clock(elap_q);
          end
        end
        Q_SETTLE: begin
          if (settle_w) begin
            bus_busy <= !is_stop_q;
            state_q  <= Q_IDLE;
          end else begin
            elap_q <= add_clock(elap_q);
          end
        end
        default: state_q <= Q_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cond_detector.sv
module i2c_cond_detector
  import i2c_cond_pkg::*;
#(
  parameter int FILT_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             hs_mode,
  input  logic [SCC_W-1:0] scc_cfg,
  input  logic             master_mode,
  output logic             start_pulse,
  output logic             stop_pulse,
  output logic             bus_busy,
  output logic             irq
);
  localparam int NLINES = 2; // index 0 = SDA, 1 = SCL

  logic [NLINES-1:0] line_raw, line_sync, line_filt;
  assign line_raw = {scl_in, sda_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (line_raw[g]),
      .sync_o  (line_sync[g]),
      .filt_o  (line_filt[g])
    );
  end

  // Named internal events for the checker
  logic sda_s_w, scl_s_w, sda_f_w, scl_f_w, sda_edge_w;
  assign sda_s_w = line_sync[0];
  assign scl_s_w = line_sync[1];
  assign sda_f_w = line_filt[0];
  assign scl_f_w = line_filt[1];

  half_t scl_high_w, sda_stable_w;
  half_t rel_thr_w, setup_thr_w, hold_thr_w, busy_thr_w;

  assign rel_thr_w   = release_half(hs_mode, scc_cfg);
  assign setup_thr_w = setup_half(hs_mode, scc_cfg);
  assign hold_thr_w  = hold_half(hs_mode, scc_cfg);
  assign busy_thr_w  = busy_half(hs_mode, scc_cfg);

  i2c_line_timers u_timers (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_f           (scl_f_w),
    .sda_f           (sda_f_w),
    .sda_edge        (sda_edge_w),
    .scl_high_half   (scl_high_w),
    .sda_stable_half (sda_stable_w)
  );

  i2c_cond_qual u_qual (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_f           (scl_f_w),
    .sda_f           (sda_f_w),
    .sda_edge        (sda_edge_w),
    .scl_high_half   (scl_high_w),
    .sda_stable_half (sda_stable_w),
    .rel_thr         (rel_thr_w),
    .setup_thr       (setup_thr_w),
    .hold_thr        (hold_thr_w),
    .busy_thr        (busy_thr_w),
    .master_mode     (master_mode),
    .start_pulse     (start_pulse),
    .stop_pulse      (stop_pulse),
    .irq             (irq),
    .bus_busy        (bus_busy)
  );
endmodule

// File: rtl/i2c_cond_detector_chk.sv
module i2c_cond_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic master_mode,
  input logic start_pulse,
  input logic stop_pulse,
  input logic irq,
  input logic sda_s_w,
  input logic scl_s_w,
  input logic sda_f_w,
  input logic scl_f_w
);
  // R2 R3
  excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pulse && stop_pulse));

  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  // R3
  stop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !stop_pulse);

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stop_pulse && !master_mode));

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pulse && !master_mode) |-> irq);

  // R6
  hold_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse || stop_pulse) |-> $past(scl_f_w));

  // R12
  sda_filt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_f_w) |-> ($past(sda_s_w) == sda_f_w));

  // R12
  scl_filt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_f_w) |-> ($past(scl_s_w) == scl_f_w));
endmodule

bind i2c_cond_detector i2c_cond_detector_chk u_chk (.*);

// File: tb/tb_i2c_cond_detector.sv
module tb_i2c_cond_detector;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int    cyc;
    int    code; // 1 start, 2 stop, 3 stop with irq
    string req;
  } exp_t;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       scl = 1'b1, sda = 1'b1;
  logic       hs = 1'b0, master = 1'b0;
  logic [4:0] scc = 5'd24;
  logic       start_pulse, stop_pulse, bus_busy, irq;

  int   cyc = 0, n_chk = 0, n_bad = 0;
  bit   exp_busy = 1'b0;
  exp_t sb_q[$];

  i2c_cond_detector dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .hs_mode(hs),
    .scc_cfg(scc), .master_mode(master), .start_pulse(start_pulse),
    .stop_pulse(stop_pulse), .bus_busy(bus_busy), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Limits restated in whole cycles of input-change spacing
  function automatic int eff(input int s);
    if (s == 0) return 2;
    return (s % 2 == 1) ? s + 1 : s;
  endfunction
  function automatic int rel_cyc();   return hs ? 4 : eff(int'(scc)) + 1;     endfunction
  function automatic int setup_cyc(); return hs ? 2 : eff(int'(scc)) / 2 + 1; endfunction
  function automatic int k_cyc();     return hs ? 2 : eff(int'(scc)) / 2 + 1; endfunction
  function automatic int m_cyc();     return hs ? 4 : eff(int'(scc)) / 2 + 2; endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor: pop expected pulses as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      int code;
      code = 0;
      if (start_pulse)          code = irq ? 5 : 1;
      else if (stop_pulse)      code = irq ? 3 : 2;
      else if (irq)             code = 4;
      if (code != 0) begin
        if (sb_q.size() == 0) check(1'b0, "R2/R3 unexpected pulse", code, 0);
        else begin
          exp_t e;
          e = sb_q.pop_front();
          check(e.code == code, e.req, code, e.code);
          check(e.cyc == cyc, e.req, cyc, e.cyc);
        end
      end
    end
  end

  // After the SDA edge driven at cycle d: end hold, check busy timing
  task automatic finish_cond(input int d, input bit is_stop, input bit pass,
                             input int hold, input string req);
    bit newb;
    newb = pass ? !is_stop : exp_busy;
    tick(hold);
    scl = 1'b0;
    while (cyc < d + 4 + m_cyc()) @(negedge clk);
    check(bus_busy == exp_busy, {req, " R7 busy before delay"}, bus_busy, exp_busy);
    @(negedge clk);
    check(bus_busy == newb, {req, " R7 busy after delay"}, bus_busy, newb);
    exp_busy = newb;
    @(posedge clk); #1;
    tick(6);
  endtask

  task automatic run_cond(input bit is_stop, input int rel, input int setup,
                          input int hold, input string req);
    bit pre, pass;
    int d;
    pre  = !is_stop;
    pass = (rel >= rel_cyc()) && (setup >= setup_cyc()) && (hold >= k_cyc() + 1);
    scl = 1'b0; tick(6);
    sda = !pre; tick(6);
    if (setup >= rel) begin
      sda = pre; tick(setup - rel);
      scl = 1'b1; tick(rel);
    end else begin
      scl = 1'b1; tick(rel - setup);
      sda = pre;  tick(setup);
    end
    d   = cyc;
    sda = !pre;
    if (pass) sb_q.push_back('{cyc: d + 5 + k_cyc(),
                               code: is_stop ? (master ? 2 : 3) : 1, req: req});
    finish_cond(d, is_stop, pass, hold, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    #(CLK_PERIOD/2);
    check(start_pulse == 1'b0, "R1 start_pulse", start_pulse, 0);
    check(stop_pulse == 1'b0,  "R1 stop_pulse", stop_pulse, 0);
    check(irq == 1'b0,         "R1 irq", irq, 0);
    check(bus_busy == 1'b0,    "R1 bus_busy", bus_busy, 0);
    tick(40);

    // Standard mode, S=24: release 25, setup 13, hold K+1 = 14 cycles
    run_cond(1'b0, 25, 13, 14, "R2 start at limits");
    run_cond(1'b1, 25, 13, 14, "R3 R10 stop in slave mode");
    run_cond(1'b0, 24, 13, 14, "R4 release one short");
    run_cond(1'b0, 25, 12, 14, "R5 setup one short");
    run_cond(1'b0, 25, 13, 13, "R6 hold one short");
    run_cond(1'b0, 30, 20, 14, "R2 start");
    run_cond(1'b0, 26, 14, 14, "R11 repeated start");
    master = 1'b1;
    run_cond(1'b1, 25, 13, 14, "R10 stop as master");
    master = 1'b0;

    // R12: one-cycle SCL glitch must not restart the release count
    scl = 1'b0; tick(6);
    sda = 1'b0; tick(6);
    sda = 1'b1; tick(2);
    scl = 1'b1; tick(30);
    scl = 1'b0; tick(1);
    scl = 1'b1; tick(2);
    begin
      int d;
      d   = cyc;
      sda = 1'b0;
      sb_q.push_back('{cyc: d + 5 + k_cyc(), code: 1, req: "R12 glitch filtered"});
      finish_cond(d, 1'b0, 1'b1, 14, "R12 glitch filtered");
    end
    run_cond(1'b1, 25, 13, 14, "R3 stop");

    // R8: high-speed fixed limits, S set to a value that would differ
    hs = 1'b1; scc = 5'd30;
    run_cond(1'b0, 4, 2, 3, "R8 hs start");
    run_cond(1'b1, 3, 2, 3, "R8 hs release short");
    run_cond(1'b1, 4, 2, 2, "R8 hs hold short");
    run_cond(1'b1, 4, 2, 3, "R8 hs stop");
    hs = 1'b0;

    // R9: odd S acts as S+1, zero acts as 2
    scc = 5'd23;
    run_cond(1'b0, 24, 13, 14, "R9 odd S release short");
    run_cond(1'b0, 25, 13, 14, "R9 odd S start");
    scc = 5'd0;
    run_cond(1'b1, 3, 2, 3, "R9 zero S stop");
    run_cond(1'b0, 2, 2, 3, "R9 zero S release short");

    tick(10);
    check(sb_q.size() == 0, "R2 R3 missing pulses", sb_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule